// File: doc/BRIEF.md
# Byte-to-Halfword Unpack Stage

This block sits directly after a memory read and widens packed bytes into 16-bit lanes. The read value arrives as up to four little-endian bytes. In pair mode, the two low bytes become two 16-bit lanes in a 32-bit result. In quad mode, all four bytes become four lanes in a 64-bit result. A per-transfer flag chooses how each lane's upper byte is filled: with zeros, or with copies of bit 7 of that lane's own byte.

The stage has no storage and adds no latency. The input and output are both valid/ready streams. A transfer completes in any cycle where both `in_valid` and `out_ready` are high. `out_valid` is a copy of `in_valid`, and `in_ready` is a copy of `out_ready`, in the same cycle. While the sink holds `out_ready` low, the source must keep `in_valid`, `in_data`, `in_quad` and `in_signed` stable, and the result stays stable with them. Neither side may make valid wait on ready.

Top module: `byte_lane_unpack`

## Requirements
- R1: With `in_quad` = 0 (pair mode), lanes 0 and 1 are built from bytes 0 and 1 of `in_data`.
- R2: With `in_quad` = 1 (quad mode), lanes 0 to 3 are built from bytes 0 to 3 of `in_data`.
- R3: Byte k of `in_data` (bits 8k+7:8k, where byte 0 is the lowest address) appears unchanged in bits 16k+7:16k of `out_data`. Lane 0 therefore occupies `out_data[15:0]`.
- R4: With `in_signed` = 0, bits 16k+15:16k+8 of every active lane are 0x00.
- R5: With `in_signed` = 1, the upper byte of a lane is 0xFF when bit 7 of that lane's source byte is 1, and 0x00 otherwise. For example, 0x81 becomes 0xFF81 and 0x7F becomes 0x007F.
- R6: In pair mode, `out_data[63:32]` is zero, and `in_data[31:16]` has no effect on any output bit.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. The data path is purely combinational, so a held input gives a held output.
- R8: Each lane's extension depends only on its own byte. Neighbouring bytes with opposite sign bits each extend by their own bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Upstream has a read value |
| in_ready | output | 1 | Stage can accept (copy of out_ready) |
| in_data | input | 32 | Raw read data, byte 0 in bits 7:0 |
| in_quad | input | 1 | 1 = four elements, 0 = two elements |
| in_signed | input | 1 | 1 = sign-extend each byte, 0 = zero-extend |
| out_valid | output | 1 | Unpacked result present (copy of in_valid) |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 64 | Unpacked lanes, lane 0 in bits 15:0 |

## Verification
Two functions can act in the same cycle: back-pressure, and the per-lane choice between zero and sign extension.

The bench provokes the overlap by holding `out_ready` low while a word is presented whose bytes alternate their top bit. It then checks two things in that cycle. First, `in_ready` must drop while `out_valid` stays high. Second, every lane must carry its own extension, with the value held steady across the stalled cycles.

Random words, in both modes and both extension settings, are compared against a reference function built from the lane rules alone.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int UNPACK_BYTE_W   = 8;
  localparam int UNPACK_LANE_W   = 16;
  localparam int UNPACK_MAX_LANE = 4;

  typedef enum logic {
    ELEM_PAIR = 1'b0,
    ELEM_QUAD = 1'b1
  } elem_count_e;

  typedef enum logic {
    EXT_ZERO = 1'b0,
    EXT_SIGN = 1'b1
  } ext_kind_e;
endpackage

// File: rtl/lane_mask_decode.sv
module lane_mask_decode #(
  parameter int MAX_LANES = 4
) (
  input  unpack_pkg::elem_count_e count_sel,
  output logic [MAX_LANES-1:0]    lane_on
);
  localparam int HALF = MAX_LANES / 2;

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_mask
    if (g < HALF) begin : g_low
      assign lane_on[g] = 1'b1;
    end else begin : g_high
      assign lane_on[g] = (count_sel == unpack_pkg::ELEM_QUAD);
    end
  end
endmodule

// File: rtl/lane_extend.sv
module lane_extend #(
  parameter int BYTE_W = 8,
  parameter int LANE_W = 16
) (
  input  logic [BYTE_W-1:0]     byte_in,
  input  unpack_pkg::ext_kind_e kind,
  input  logic                  enable,
  output logic [LANE_W-1:0]     lane_out
);
  localparam int FILL_W = LANE_W - BYTE_W;

  logic fill_bit;

  always_comb begin
    fill_bit = (kind == unpack_pkg::EXT_SIGN) && byte_in[BYTE_W-1];
    if (enable) lane_out = {{FILL_W{fill_bit}}, byte_in};
    else        lane_out = '0;
  end
endmodule

// File: rtl/byte_lane_unpack.sv
module byte_lane_unpack #(
  parameter int MAX_LANES = unpack_pkg::UNPACK_MAX_LANE,
  parameter int BYTE_W    = unpack_pkg::UNPACK_BYTE_W,
  parameter int LANE_W    = unpack_pkg::UNPACK_LANE_W,
  localparam int IN_W     = MAX_LANES * BYTE_W,
  localparam int OUT_W    = MAX_LANES * LANE_W
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_quad,
  input  logic             in_signed,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  unpack_pkg::elem_count_e count_sel;
  unpack_pkg::ext_kind_e   kind;
  logic [MAX_LANES-1:0]    lane_on;

  assign count_sel = unpack_pkg::elem_count_e'(in_quad);
  assign kind      = unpack_pkg::ext_kind_e'(in_signed);

  // Handshake passes straight through; no storage in this stage.
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  lane_mask_decode #(.MAX_LANES(MAX_LANES)) u_mask (
    .count_sel (count_sel),
    .lane_on   (lane_on)
  );

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    lane_extend #(.BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_ext (
      .byte_in  (in_data[g*BYTE_W +: BYTE_W]),
      .kind     (kind),
      .enable   (lane_on[g]),
      .lane_out (out_data[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/byte_lane_unpack_chk.sv
module byte_lane_unpack_chk #(
  parameter int MAX_LANES = 4,
  parameter int BYTE_W    = 8,
  parameter int LANE_W    = 16
) (
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [MAX_LANES*BYTE_W-1:0] in_data,
  input logic                        in_quad,
  input logic                        in_signed,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [MAX_LANES*LANE_W-1:0] out_data
);
  localparam int HALF   = MAX_LANES / 2;
  localparam int FILL_W = LANE_W - BYTE_W;

  always_comb begin
    p_valid_r7: assert (out_valid == in_valid && in_ready == out_ready)
      else $error("handshake not passed through");
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane_chk
    logic active;
    logic [BYTE_W-1:0] src;
    logic [LANE_W-1:0] lane;
    assign active = (g < HALF) || in_quad;
    assign src    = in_data[g*BYTE_W +: BYTE_W];
    assign lane   = out_data[g*LANE_W +: LANE_W];

    always_comb begin
      if (active) begin
        p_lowbyte_r3: assert (lane[BYTE_W-1:0] == src)
          else $error("lane %0d low byte mismatch", g);
        if (!in_signed) begin
          p_upper_zero_r4: assert (lane[LANE_W-1:BYTE_W] == '0)
            else $error("lane %0d upper not zero", g);
        end else begin
          p_sign_r5: assert (lane[LANE_W-1:BYTE_W] == {FILL_W{src[BYTE_W-1]}})
            else $error("lane %0d sign fill wrong", g);
        end
      end else begin
        p_high_zero_r6: assert (lane == '0)
          else $error("inactive lane %0d not zero", g);
      end
    end
  end
endmodule

bind byte_lane_unpack byte_lane_unpack_chk #(
  .MAX_LANES (MAX_LANES),
  .BYTE_W    (BYTE_W),
  .LANE_W    (LANE_W)
) u_chk (.*);

// File: tb/byte_lane_unpack_bench.sv
module byte_lane_unpack_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid, in_ready, in_quad, in_signed, out_valid, out_ready;
  logic [31:0] in_data;
  logic [63:0] out_data;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  byte_lane_unpack u_byte_lane_unpack (
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_quad (in_quad), .in_signed (in_signed), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data)
  );

  function automatic logic [63:0] model(logic [31:0] d, logic q, logic s);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = d[8*i +: 8];
      if (i < 2 || q) r[16*i +: 16] = {(s && b[7]) ? 8'hFF : 8'h00, b};
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] d, logic q, logic s);
    @(negedge clk);
    in_data = d; in_quad = q; in_signed = s; in_valid = 1'b1;
    #2;
  endtask

  initial begin
    in_valid = 0; in_data = '0; in_quad = 0; in_signed = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #2;
    check("reset R7 out_valid idle", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    // R1 R5: pair signed, 0x81 then 0x02
    apply(32'hAAAA_0281, 0, 1); check("R1 R5 pair signed", out_data, 64'h0000_0000_0002_FF81);
    apply(32'h0000_0281, 0, 0); check("R1 R4 pair unsigned", out_data, 64'h0000_0000_0002_0081);
    // R2 R3: quad lane order
    apply(32'h0403_0201, 1, 0); check("R2 R3 quad order", out_data, 64'h0004_0003_0002_0001);
    apply(32'h8483_8281, 1, 1); check("R2 R5 quad all negative", out_data, 64'hFF84_FF83_FF82_FF81);
    // R5 boundaries
    apply(32'h0000_807F, 0, 1); check("R5 0x7F/0x80 boundary", out_data, 64'h0000_0000_FF80_007F);
    apply(32'hFFFF_FFFF, 1, 0); check("R4 all ones unsigned", out_data, 64'h00FF_00FF_00FF_00FF);
    // R8 alternating signs
    apply(32'h807F_807F, 1, 1); check("R8 alternating signs", out_data, 64'hFF80_007F_FF80_007F);
    apply(32'h7F80_7F80, 1, 1); check("R8 alternating inverse", out_data, 64'h007F_FF80_007F_FF80);
    // R6: upper input bits ignored in pair mode
    apply(32'hFFFF_0102, 0, 1); check("R6 pair upper garbage", out_data, 64'h0000_0000_0001_0002);
    apply(32'h0000_0102, 0, 1); check("R6 pair upper clear", out_data, 64'h0000_0000_0001_0002);

    // R7: back-pressure in the same cycle as mixed-sign extension
    apply(32'h01FF_7F80, 1, 1);
    out_ready = 1'b0; #1;
    check("R7 in_ready drops", {63'd0, in_ready}, 64'd0);
    check("R7 out_valid held", {63'd0, out_valid}, 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      check("R7 R8 stalled data stable", out_data, 64'h0001_FFFF_007F_FF80);
    end
    out_ready = 1'b1; #1;
    check("R7 in_ready returns", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b0; #1;
    check("R7 out_valid follows", {63'd0, out_valid}, 64'd0);

    // random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d = $urandom;
      logic q = $urandom % 2;
      logic s = $urandom % 2;
      out_ready = $urandom % 2;
      apply(d, q, s);
      check(q ? "R2 random quad" : "R1 random pair", out_data, model(d, q, s));
      check("R7 random ready", {63'd0, in_ready}, {63'd0, out_ready});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule